// File: doc/BRIEF.md
# Audio Channel FIFO Data Port

This block is the register-side data port of one audio channel. A single bus address serves two separate queues. A read at that address takes the oldest sample from a receive queue, which the serial receive logic fills. A write at the same address adds a sample to a transmit queue. The transmit logic empties that queue one sample per frame into a 64-bit frame shift register, and the register drives the serial data pin.

Both queues are shift-style, fall-through structures. A new sample enters the top slot. Each clock it drops one slot while the slot below it is empty or is emptying in the same cycle, so it comes to rest on the lowest free slot. Only the bottom slot can be read. Pulling the enable input low empties both queues, clears the sticky error flags and clears the frame shifter. Software polls two status outputs: one shows that the receive queue has a sample to read, the other shows that the transmit queue can take another sample.

Top module: `audio_chan_port`

## Requirements
- R1: A bus read at the port address returns the bottom (oldest) receive sample in bits 15:0 of `bus_rdata` on the clock after the read cycle and removes it. The remaining samples keep their arrival order.
- R2: Bits 31:16 of `bus_rdata` are always zero. Bits 31:16 of a written word have no effect on what is transmitted.
- R3: A bus access whose address differs from `PORT_ADDR` pushes nothing, pops nothing and leaves `bus_rdata` unchanged.
- R4: A receive sample pushed into an empty receive queue enters the top slot at the push edge. It reaches the bottom slot DEPTH edges after the push is presented (8 by default), and `rx_not_empty` rises in that cycle and not earlier.
- R5: The transmit queue holds DEPTH (8) samples. `tx_not_full` is 1 while any slot is free and 0 once all DEPTH slots are occupied.
- R6: A write arriving when the transmit queue cannot accept it is dropped and sets `tx_ovf`. `tx_ovf` stays set until the block is disabled or reset.
- R7: A read at the port address while the receive queue has no sample at its bottom slot returns zero and sets `rx_unf`. `rx_unf` stays set until the block is disabled or reset.
- R8: While `en` is 0, both queues are empty, both flags are clear, `bus_rdata` and `sdout` are 0, and pushes and writes are ignored.
- R9: On a `frame_start` pulse, the bottom transmit sample is loaded into bits 63:48 of the frame register and removed from the queue. All other frame bits are zero. If the queue has no sample at its bottom, the whole frame is zero.
- R10: `sdout` shows frame bit 63 in the cycle after `frame_start`. Each `ser_tick` cycle then shifts the frame one bit toward the MSB, so the 64 frame bits leave MSB first, one per tick.
- R11: A receive push arriving while all DEPTH receive slots are occupied is dropped, and the stored samples are unchanged.
- R12: After reset, `bus_rdata` is 0, `sdout` is 0, `rx_not_empty` is 0, `tx_not_full` is 1, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; 0 flushes both queues |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Bus address, compared with `PORT_ADDR` |
| bus_wdata | input | 32 | Write data; bits 15:0 hold the sample |
| bus_rdata | output | 32 | Registered read data |
| rx_push | input | 1 | Receive logic presents a sample |
| rx_sample | input | 16 | Received sample |
| frame_start | input | 1 | Frame boundary; loads the frame register |
| ser_tick | input | 1 | Serial bit enable; shifts the frame register |
| sdout | output | 1 | Serial data output |
| rx_not_empty | output | 1 | Receive bottom slot holds a sample |
| tx_not_full | output | 1 | Transmit queue has a free slot |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
The embedded properties check the following on every cycle. The upper read bits are zero. A refused write or a read of an empty queue raises its flag on the next edge, and the flags persist. Disable empties everything. A pop moves slot 1 into slot 0. A full queue holds its top sample. Each serial tick advances the frame by exactly one bit. Only the bench scenarios can show that end-to-end arrival order survives bursts, drops and interleaved reads, that the fall-through latency is exactly DEPTH edges, that frames carry the written samples in the right bit positions, and that foreign addresses leave every queue untouched.

// File: rtl/acp_pkg.sv
package acp_pkg;
   typedef struct packed {
      logic rd;
      logic wr;
   } acc_t;

   localparam int unsigned ACP_BUS_W  = 32;
   localparam int unsigned ACP_DATA_W = 16;
endpackage

// File: rtl/acp_bus_decode.sv
module acp_bus_decode #(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h80
) (
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output acp_pkg::acc_t     acc
);
   logic hit;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("acp_bus_decode: ADDR_W must be at least 1");
   end

   assign hit    = bus_cs && (bus_addr == PORT_ADDR);
   assign acc.rd = hit && !bus_we;
   assign acc.wr = hit && bus_we;
endmodule

// File: rtl/acp_shift_fifo.sv
module acp_shift_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head_data,
   output logic         head_valid,
   output logic         accept,
   output logic         full
);
   localparam int unsigned TOP = DEPTH - 1;

   logic [DEPTH-1:0] vld;
   logic [DEPTH-1:0] vld_n;
   logic [DEPTH-1:0] free;
   logic [DEPTH-1:0] take_above;
   logic [W-1:0]     slot_q [DEPTH];
   logic             load_top;

   if (DEPTH < 2) begin : g_bad_depth
      $error("acp_shift_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("acp_shift_fifo: W must be at least 1");
   end

   // free[i]: slot i is empty after this edge unless refilled from above
   always_comb begin
      free[0] = !vld[0] || pop;
      for (int i = 1; i < DEPTH; i++) begin
         free[i] = !vld[i] || free[i-1];
      end
   end

   assign load_top = push && free[TOP];

   always_comb begin
      for (int i = 0; i < TOP; i++) begin
         take_above[i] = vld[i+1] && free[i];
         vld_n[i]      = take_above[i] || (vld[i] && !free[i]);
      end
      take_above[TOP] = load_top;
      vld_n[TOP]      = load_top || (vld[TOP] && !free[TOP]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (flush) begin
         vld <= '0;
      end else begin
         vld <= vld_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
         for (int i = 0; i < TOP; i++) begin
            if (take_above[i]) slot_q[i] <= slot_q[i+1];
         end
         if (load_top) slot_q[TOP] <= push_data;
      end
   end

   assign head_data  = slot_q[0];
   assign head_valid = vld[0];
   assign accept     = free[TOP];
   assign full       = &vld;

   // R1: a pop with a sample waiting in slot 1 brings that sample to the bottom
   p_pop_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && vld[0] && vld[1] && !flush) |=> (vld[0] && slot_q[0] == $past(slot_q[1])));

   // R11: a full queue that is not popped keeps its top sample
   p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !flush) |=> (vld[TOP] && slot_q[TOP] == $past(slot_q[TOP])));

   // R8: flush leaves every slot empty
   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld == '0));
endmodule

// File: rtl/acp_frame_tx.sv
module acp_frame_tx #(
   parameter int unsigned FRAME_W   = 64,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SLOT_LSB  = 48,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              frame_start,
   input  logic              ser_tick,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic              take,
   output logic              sdout
);
   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] load_val;

   if (SLOT_LSB + DATA_W > FRAME_W) begin : g_bad_slot
      $error("acp_frame_tx: sample slot exceeds the frame");
   end
   if (FRAME_W < 2) begin : g_bad_frame
      $error("acp_frame_tx: FRAME_W must be at least 2");
   end

   always_comb begin
      load_val = '0;
      if (smp_valid) load_val[SLOT_LSB +: DATA_W] = smp_data;
   end

   assign take = frame_start && smp_valid && !flush;

   if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sreg <= '0;
         end else if (flush) begin
            sreg <= '0;
         end else if (frame_start) begin
            sreg <= load_val;
         end else if (ser_tick) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
         end
      end
      assign sdout = sreg[FRAME_W-1];

      // R10: one tick advances the output by exactly one frame bit
      p_tick_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (ser_tick && !frame_start && !flush) |=> (sdout == $past(sreg[FRAME_W-2])));
   end else begin : g_lsb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sreg <= '0;
         end else if (flush) begin
            sreg <= '0;
         end else if (frame_start) begin
            sreg <= load_val;
         end else if (ser_tick) begin
            sreg <= {1'b0, sreg[FRAME_W-1:1]};
         end
      end
      assign sdout = sreg[0];

      p_tick_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (ser_tick && !frame_start && !flush) |=> (sdout == $past(sreg[1])));
   end

   // R9: a frame started with nothing queued is all zeros
   p_empty_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !smp_valid && !flush) |=> (sreg == '0));

   // R10: with no tick and no frame start the output holds
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_tick && !frame_start && !flush) |=> $stable(sdout));
endmodule

// File: rtl/audio_chan_port.sv
module audio_chan_port #(
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h80,
   parameter int unsigned BUS_W     = acp_pkg::ACP_BUS_W,
   parameter int unsigned DATA_W    = acp_pkg::ACP_DATA_W,
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned FRAME_W   = 64,
   parameter int unsigned SLOT_LSB  = 48,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_sample,
   input  logic              frame_start,
   input  logic              ser_tick,
   output logic              sdout,
   output logic              rx_not_empty,
   output logic              tx_not_full,
   output logic              tx_ovf,
   output logic              rx_unf
);
   localparam int unsigned PAD_W = BUS_W - DATA_W;

   acp_pkg::acc_t     acc;
   logic              flush;
   logic              rx_head_vld, rx_accept, rx_full;
   logic [DATA_W-1:0] rx_head;
   logic              tx_head_vld, tx_accept, tx_full;
   logic [DATA_W-1:0] tx_head;
   logic              tx_take;
   logic              rd_go, wr_go;

   if (DATA_W >= BUS_W) begin : g_bad_bus
      $error("audio_chan_port: DATA_W must be narrower than BUS_W");
   end

   assign flush = !en;
   assign rd_go = acc.rd && en;
   assign wr_go = acc.wr && en;

   acp_bus_decode #(
      .ADDR_W   (ADDR_W),
      .PORT_ADDR(PORT_ADDR)
   ) u_dec (
      .bus_cs  (bus_cs),
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .acc     (acc)
   );

   acp_shift_fifo #(
      .W    (DATA_W),
      .DEPTH(DEPTH)
   ) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (rx_push && en),
      .push_data (rx_sample),
      .pop       (rd_go),
      .head_data (rx_head),
      .head_valid(rx_head_vld),
      .accept    (rx_accept),
      .full      (rx_full)
   );

   acp_shift_fifo #(
      .W    (DATA_W),
      .DEPTH(DEPTH)
   ) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (wr_go),
      .push_data (bus_wdata[DATA_W-1:0]),
      .pop       (tx_take),
      .head_data (tx_head),
      .head_valid(tx_head_vld),
      .accept    (tx_accept),
      .full      (tx_full)
   );

   acp_frame_tx #(
      .FRAME_W  (FRAME_W),
      .DATA_W   (DATA_W),
      .SLOT_LSB (SLOT_LSB),
      .MSB_FIRST(MSB_FIRST)
   ) u_ftx (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .frame_start(frame_start),
      .ser_tick   (ser_tick),
      .smp_valid  (tx_head_vld),
      .smp_data   (tx_head),
      .take       (tx_take),
      .sdout      (sdout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (flush) begin
         bus_rdata <= '0;
      end else if (rd_go) begin
         bus_rdata <= {{PAD_W{1'b0}}, (rx_head_vld ? rx_head : {DATA_W{1'b0}})};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_unf <= 1'b0;
      end else if (flush) begin
         tx_ovf <= 1'b0;
         rx_unf <= 1'b0;
      end else begin
         if (wr_go && !tx_accept) tx_ovf <= 1'b1;
         if (rd_go && !rx_head_vld) rx_unf <= 1'b1;
      end
   end

   assign rx_not_empty = rx_head_vld;
   assign tx_not_full  = !tx_full;

   // R2: reserved read bits never carry data
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_W-1:DATA_W] == '0);

   // R6: a write refused by a full queue raises the overflow flag
   p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && acc.wr && !tx_not_full && !frame_start) |=> tx_ovf);

   // R6: the overflow flag persists while enabled
   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tx_ovf) |=> tx_ovf);

   // R7: reading an empty queue flags underflow and returns zero
   p_unf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && acc.rd && !rx_not_empty) |=> (rx_unf && bus_rdata == '0));

   // R8: disable clears every queue, flag and output
   p_disable_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rx_not_empty && tx_not_full && !tx_ovf && !rx_unf && !sdout && bus_rdata == '0));
endmodule

// File: tb/tb_audio_chan_port.sv
`timescale 1ns/1ps
module tb_audio_chan_port;
   localparam int DEPTH = 8;
   localparam logic [7:0] PADDR = 8'h80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        bus_cs = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_push = 1'b0;
   logic [15:0] rx_sample = '0;
   logic        frame_start = 1'b0;
   logic        ser_tick = 1'b0;
   logic        sdout, rx_not_empty, tx_not_full, tx_ovf, rx_unf;

   int n_chk = 0;
   int n_fail = 0;

   logic [15:0] rxq[$];
   logic [15:0] txq[$];
   logic        ovf_m = 1'b0;
   logic        unf_m = 1'b0;
   logic [31:0] last_rd = '0;

   always #2 clk = ~clk;

   audio_chan_port dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_push(rx_push), .rx_sample(rx_sample),
      .frame_start(frame_start), .ser_tick(ser_tick), .sdout(sdout),
      .rx_not_empty(rx_not_empty), .tx_not_full(tx_not_full),
      .tx_ovf(tx_ovf), .rx_unf(rx_unf)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit have, input logic [15:0] s);
      return have ? {s, 48'h0} : 64'h0;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (DEPTH + 1) tick();
   endtask

   task automatic push_rx(input logic [15:0] d);
      rx_push = 1'b1; rx_sample = d;
      tick();
      rx_push = 1'b0;
      if (en) begin
         if (rxq.size() < DEPTH) rxq.push_back(d);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_cs = 1'b0; bus_we = 1'b0;
      if (en && a == PADDR) begin
         if (txq.size() < DEPTH) txq.push_back(d[15:0]);
         else ovf_m = 1'b1;
      end
   endtask

   task automatic bus_read(input logic [7:0] a, input string req);
      logic [31:0] exp;
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      tick();
      bus_cs = 1'b0;
      exp = last_rd;
      if (a == PADDR) begin
         if (rxq.size() > 0) exp = {16'h0, rxq.pop_front()};
         else begin exp = 32'h0; unf_m = 1'b1; end
      end
      last_rd = exp;
      chk(bus_rdata == exp, req, {32'h0, bus_rdata}, {32'h0, exp});
   endtask

   task automatic run_frame(input string req);
      logic [63:0] got;
      logic [63:0] exp;
      exp = (txq.size() > 0) ? exp_frame(1'b1, txq.pop_front()) : 64'h0;
      frame_start = 1'b1;
      tick();
      frame_start = 1'b0;
      got[63] = sdout;
      ser_tick = 1'b1;
      for (int i = 62; i >= 0; i--) begin
         tick();
         got[i] = sdout;
      end
      ser_tick = 1'b0;
      chk(got == exp, req, got, exp);
   endtask

   task automatic chk_status(input string tag);
      chk(rx_not_empty == (rxq.size() > 0), {tag, " R4 rx_not_empty"}, {63'h0, rx_not_empty}, {63'h0, rxq.size() > 0});
      chk(tx_not_full == (txq.size() < DEPTH), {tag, " R5 tx_not_full"}, {63'h0, tx_not_full}, {63'h0, txq.size() < DEPTH});
      chk(tx_ovf == ovf_m, {tag, " R6 tx_ovf"}, {63'h0, tx_ovf}, {63'h0, ovf_m});
      chk(rx_unf == unf_m, {tag, " R7 rx_unf"}, {63'h0, rx_unf}, {63'h0, unf_m});
   endtask

   task automatic do_disable();
      en = 1'b0;
      tick();
      rxq.delete(); txq.delete();
      ovf_m = 1'b0; unf_m = 1'b0; last_rd = '0;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R12: reset state
      chk(bus_rdata == 0, "R12 rdata", {32'h0, bus_rdata}, 0);
      chk(sdout == 0, "R12 sdout", {63'h0, sdout}, 0);
      chk_status("R12");
      en = 1'b1;
      tick();

      // R4: fall-through latency into an empty receive queue
      rx_push = 1'b1; rx_sample = 16'hA5C3;
      for (int k = 1; k <= DEPTH; k++) begin
         tick();
         rx_push = 1'b0;
         chk(rx_not_empty == (k == DEPTH), "R4 latency", {63'h0, rx_not_empty}, {63'h0, k == DEPTH});
      end
      rxq.push_back(16'hA5C3);

      // R1 order, then R7 underflow
      push_rx(16'h1111); push_rx(16'h2222);
      settle();
      bus_read(PADDR, "R1 oldest first");
      bus_read(PADDR, "R1 order");
      bus_read(PADDR, "R1 order last");
      bus_read(PADDR, "R7 empty read zero");
      chk_status("R7");

      // R3: foreign address
      push_rx(16'h3333);
      settle();
      bus_write(8'h84, 32'h0000_7777);
      bus_read(8'h81, "R3 foreign read holds rdata");
      bus_read(PADDR, "R3 sample not popped");
      run_frame("R3 foreign write not queued");

      // R11: overfill receive queue
      for (int i = 0; i < DEPTH + 2; i++) push_rx(16'h4000 + 16'(i));
      settle();
      chk_status("R11");
      for (int i = 0; i < DEPTH + 1; i++) bus_read(PADDR, "R11 drop beyond depth");

      // R5, R6: capacity and overflow
      for (int i = 0; i < DEPTH - 1; i++) bus_write(PADDR, 32'hDEAD_0000 + 32'(i));
      settle();
      chk_status("R5 one free");
      bus_write(PADDR, 32'hBEEF_00AA);
      settle();
      chk_status("R5 full");
      bus_write(PADDR, 32'h0000_0BAD);
      tick();
      chk_status("R6 overflow");

      // R9, R10, R2: frames carry samples, upper write bits discarded
      for (int i = 0; i < DEPTH + 1; i++) run_frame("R9 R10 R2 frame");
      chk_status("R9 drained");

      // R8: disable flushes and ignores input
      push_rx(16'h5555); bus_write(PADDR, 32'h0000_6666);
      settle();
      do_disable();
      push_rx(16'h7777); bus_write(PADDR, 32'h0000_8888);
      chk(bus_rdata == 0 && sdout == 0, "R8 outputs cleared", {31'h0, sdout, bus_rdata}, 0);
      chk_status("R8 cleared");
      en = 1'b1;
      settle();
      chk_status("R8 re-enable empty");
      run_frame("R8 nothing queued");

      // random mix
      for (int r = 0; r < 40; r++) begin
         int n;
         n = int'($urandom_range(0, DEPTH + 2));
         for (int i = 0; i < n; i++) push_rx(16'($urandom));
         n = int'($urandom_range(0, DEPTH + 2));
         for (int i = 0; i < n; i++) bus_write(PADDR, $urandom);
         settle();
         chk_status("rand");
         n = int'($urandom_range(0, DEPTH + 1));
         for (int i = 0; i < n; i++) bus_read(PADDR, "R1 R7 rand read");
         n = int'($urandom_range(0, 3));
         for (int i = 0; i < n; i++) run_frame("R9 R10 rand frame");
         if ($urandom_range(0, 7) == 0) begin
            do_disable();
            en = 1'b1;
         end
         settle();
         chk_status("rand end");
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule